// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a data word left logically, right logically or right arithmetically by a count supplied from a register, and returns the shifted word together with a carry flag and an extend flag. It is the shift datapath of an integer execution unit. The count is used modulo 64, so it covers counts beyond the word width, and each range of counts has its own carry rule.

One operation is launched by raising `in_valid` for one clock with the operands present. The value, count, kind and previous carry are captured on that edge. The result, carry and extend appear on the registered outputs at the same edge, and `out_done` stays high for that one cycle. Between launches the outputs keep their last values.

Top module: `shift_flag_unit`

## Requirements
- R1: The 6-bit `in_count` is taken as an unsigned count from 0 to 63, and every value in that range is a legal shift.
- R2: A count of 0 returns `in_value` unchanged, and the carry output equals `in_carry`.
- R3: A left shift (kind 2'b00) by n in 1..31 gives `in_value << n`, and the carry is input bit (32 − n).
- R4: A logical right shift (kind 2'b01) by n in 1..31 gives `in_value >> n` with zero fill, and the carry is input bit (n − 1).
- R5: An arithmetic right shift (kind 2'b10 or 2'b11) by n in 1..31 fills with input bit 31, and the carry is input bit (n − 1).
- R6: A logical shift by exactly 32 gives zero. The carry is input bit 0 for a left shift and input bit 31 for a logical right shift.
- R7: A logical shift (left or right) by 33..63 gives zero with carry 0.
- R8: An arithmetic right shift by 32..63 sets every result bit to input bit 31, and the carry equals input bit 31.
- R9: Every time a result is produced, `out_extend` equals `out_carry`.
- R10: Results appear on the clock edge that samples `in_valid` high, with `out_done` high for exactly that cycle. When `in_valid` is low, `out_done` is low and the outputs hold.
- R11: During synchronous active-low reset, `out_result`, `out_carry`, `out_extend` and `out_done` are all 0.
- R12: The kind field decodes as 2'b00 left, 2'b01 logical right, and either value with bit 1 set as arithmetic right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Launch strobe; operands captured when high |
| in_value | input | 32 | Word to shift |
| in_count | input | 6 | Shift count, 0..63 |
| in_kind | input | 2 | Shift kind (R12 encoding) |
| in_carry | input | 1 | Previous carry flag |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Carry out |
| out_extend | output | 1 | Extend out |
| out_done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 6-bit count. With these values the whole count range is reached, including zero, 1..31, exactly 32 and 33..63, so every carry rule is exercised for both the 32 boundary and the wrap at 64. The bench mixes random operands of all four kind codes with directed single-bit and sign-boundary patterns. It also checks the hold behaviour and `out_done` while the inputs change with the strobe low.

// File: rtl/shift_flag_pkg.sv
// Shared types for the shifter: kind encoding and count classification.
package shift_flag_pkg;

    // Shift kind; any code with bit 1 set is an arithmetic right shift.
    typedef enum logic [1:0] {
        SK_LEFT      = 2'b00,
        SK_RIGHT_LOG = 2'b01,
        SK_RIGHT_ARI = 2'b10,
        SK_RIGHT_AR2 = 2'b11
    } shift_kind_e;

    // One-hot class of a count relative to the word width.
    typedef struct packed {
        logic zero;     // count == 0
        logic inrange;  // 1 .. width-1
        logic exact;    // count == width
        logic beyond;   // width+1 .. max
    } count_class_t;

endpackage

// File: rtl/shift_count_class.sv
// Classifies a shift count against the word width.
// Assumes CNT_W is wide enough to hold DATA_W.
module shift_count_class
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [CNT_W-1:0] cnt,
    output count_class_t     cls
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    // Compare the count against zero and the width.
    always_comb begin
        cls.zero    = (cnt == '0);
        cls.exact   = (cnt == WIDTH_CNT);
        cls.beyond  = (cnt >  WIDTH_CNT);
        cls.inrange = !cls.zero && (cnt < WIDTH_CNT);
    end

endmodule

// File: rtl/shift_barrel_core.sv
// Logarithmic barrel shifter for counts 0..DATA_W-1.
// A left shift is done by reversing the word, shifting right and reversing back.
// Assumes DATA_W is a power of two.
module shift_barrel_core #(
    parameter int DATA_W = 32,
    parameter int SW     = 5
) (
    input  logic [DATA_W-1:0] value,
    input  logic [SW-1:0]     amt,
    input  logic              dir_left,
    input  logic              fill_bit,
    output logic [DATA_W-1:0] shifted
);
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stage [0:SW];

    // Bit reversal of the input and of the last stage.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = value[DATA_W-1-i];
        assign rev_out[i] = stage[SW][DATA_W-1-i];
    end

    // The first stage picks the word orientation from the direction.
    assign stage[0] = dir_left ? rev_in : value;

    // Each stage conditionally shifts right by a power of two.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k] ? {{SH{fill_bit}}, stage[k][DATA_W-1:SH]}
                                   : stage[k];
    end

    // Undo the reversal for a left shift.
    assign shifted = dir_left ? rev_out : stage[SW];

endmodule

// File: rtl/shift_carry_select.sv
// Chooses the carry-out bit for each count class and shift kind.
// Assumes cls is one-hot.
module shift_carry_select
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int SW     = 5
) (
    input  logic [DATA_W-1:0] value,
    input  logic [CNT_W-1:0]  cnt,
    input  count_class_t      cls,
    input  logic              dir_left,
    input  logic              arith,
    input  logic              prev_carry,
    output logic              carry
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    logic [CNT_W-1:0] left_idx;
    logic [CNT_W-1:0] right_idx;
    logic             sign_bit;

    // Bit positions of the last bit shifted out, for in-range counts.
    always_comb begin
        left_idx  = WIDTH_CNT - cnt;
        right_idx = cnt - CNT_W'(1);
        sign_bit  = value[DATA_W-1];
    end

    // Carry rule for each count class.
    always_comb begin
        carry = 1'b0;
        if (cls.zero) begin
            carry = prev_carry;
        end else if (cls.inrange) begin
            carry = dir_left ? value[left_idx[SW-1:0]] : value[right_idx[SW-1:0]];
        end else if (cls.exact) begin
            if (arith)         carry = sign_bit;
            else if (dir_left) carry = value[0];
            else               carry = sign_bit;
        end else if (cls.beyond) begin
            carry = arith ? sign_bit : 1'b0;
        end
    end

endmodule

// File: rtl/shift_flag_unit.sv
// Shifter with carry and extend flags and a registered output stage.
// Operands are captured when in_valid is high. The result, flags and a
// one-cycle done pulse appear on that edge, and the outputs hold otherwise.
// Assumes DATA_W is a power of two and that the count is used modulo 2*DATA_W.
module shift_flag_unit
    import shift_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SW    = $clog2(DATA_W),
    localparam int CNT_W = SW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [1:0]        in_kind,
    input  logic              in_carry,
    output logic [DATA_W-1:0] out_result,
    output logic              out_carry,
    output logic              out_extend,
    output logic              out_done
);
    count_class_t      cls;
    logic              dir_left;
    logic              arith;
    logic              fill_bit;
    logic [DATA_W-1:0] barrel_out;
    logic [DATA_W-1:0] result_nxt;
    logic              carry_nxt;

    // Decode the kind field.
    always_comb begin
        dir_left = (shift_kind_e'(in_kind) == SK_LEFT);
        arith    = in_kind[1];
        fill_bit = arith & in_value[DATA_W-1];
    end

    shift_count_class #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_class (
        .cnt (in_count),
        .cls (cls)
    );

    shift_barrel_core #(.DATA_W(DATA_W), .SW(SW)) u_barrel (
        .value    (in_value),
        .amt      (in_count[SW-1:0]),
        .dir_left (dir_left),
        .fill_bit (fill_bit),
        .shifted  (barrel_out)
    );

    shift_carry_select #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SW(SW)) u_carry (
        .value      (in_value),
        .cnt        (in_count),
        .cls        (cls),
        .dir_left   (dir_left),
        .arith      (arith),
        .prev_carry (in_carry),
        .carry      (carry_nxt)
    );

    // Choose the result for each count class.
    always_comb begin
        if (cls.zero)         result_nxt = in_value;
        else if (cls.inrange) result_nxt = barrel_out;
        else                  result_nxt = {DATA_W{fill_bit}};
    end

    // Output register: capture on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_carry  <= 1'b0;
            out_extend <= 1'b0;
            out_done   <= 1'b0;
        end else begin
            out_done <= in_valid;
            if (in_valid) begin
                out_result <= result_nxt;
                out_carry  <= carry_nxt;
                out_extend <= carry_nxt;
            end
        end
    end

endmodule

// File: rtl/shift_flag_unit_chk.sv
// Temporal checks on the shifter's ports, bound to every instance.
module shift_flag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_value,
    input logic [CNT_W-1:0]  in_count,
    input logic [1:0]        in_kind,
    input logic              in_carry,
    input logic [DATA_W-1:0] out_result,
    input logic              out_carry,
    input logic              out_extend,
    input logic              out_done
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    p_done_follows_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && $stable(out_result) && $stable(out_carry)));

    p_extend_tracks_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_extend == out_carry));

    p_zero_count_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_count == '0) |=>
            (out_result == $past(in_value) && out_carry == $past(in_carry)));

    p_logical_beyond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind[1] && in_count > WIDTH_CNT) |=>
            (out_result == '0 && !out_carry));

    p_arith_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[1] && in_count >= WIDTH_CNT) |=>
            (out_result == {DATA_W{$past(in_value[DATA_W-1])}}
             && out_carry == $past(in_value[DATA_W-1])));

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .in_count   (in_count),
    .in_kind    (in_kind),
    .in_carry   (in_carry),
    .out_result (out_result),
    .out_carry  (out_carry),
    .out_extend (out_extend),
    .out_done   (out_done)
);

// File: tb/shift_flag_unit_bench.sv
`timescale 1ns/1ps
module shift_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [5:0]  in_count = '0;
    logic [1:0]  in_kind = '0;
    logic        in_carry = 1'b0;
    logic [31:0] out_result;
    logic        out_carry, out_extend, out_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shift_flag_unit u_shift_flag_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_count(in_count), .in_kind(in_kind), .in_carry(in_carry),
        .out_result(out_result), .out_carry(out_carry),
        .out_extend(out_extend), .out_done(out_done)
    );

    // Expected {carry, result} computed from the requirements.
    function automatic logic [32:0] model(logic [31:0] v, logic [5:0] n,
                                          logic [1:0] k, logic c);
        int unsigned nn = n;
        bit ar = k[1];
        bit lf = (k == 2'b00);
        if (nn == 0) return {c, v};
        if (nn < 32) begin
            if (lf) return {v[32-nn], v << nn};
            if (ar) return {v[nn-1], 32'($signed(v) >>> nn)};
            return {v[nn-1], v >> nn};
        end
        if (ar) return {v[31], {32{v[31]}}};
        if (nn == 32) return {(lf ? v[0] : v[31]), 32'h0};
        return 33'h0;
    endfunction

    // Requirement tag for a given operation.
    function automatic string tag(logic [5:0] n, logic [1:0] k);
        int unsigned nn = n;
        if (nn == 0) return "R2";
        if (k[1]) return (nn < 32) ? "R5" : "R8";
        if (nn < 32) return (k == 2'b00) ? "R3" : "R4";
        return (nn == 32) ? "R6" : "R7";
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One launch: drive at negedge, sample at the following negedge.
    task automatic op(logic [31:0] v, logic [5:0] n, logic [1:0] k, logic c);
        logic [32:0] e;
        e = model(v, n, k, c);
        @(negedge clk);
        in_valid = 1'b1; in_value = v; in_count = n; in_kind = k; in_carry = c;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_result == e[31:0], tag(n, k), 64'(out_result), 64'(e[31:0]));
        check(out_carry == e[32], tag(n, k), 64'(out_carry), 64'(e[32]));
        check(out_extend == out_carry, "R9", 64'(out_extend), 64'(out_carry));
        check(out_done == 1'b1, "R10", 64'(out_done), 64'd1);
    endtask

    initial begin
        logic [31:0] held;
        logic        heldc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_result == '0 && !out_carry && !out_extend && !out_done, "R11",
              {out_result, 29'h0, out_carry, out_extend, out_done}, 64'h0);
        rst_n = 1'b1;

        // Directed corners
        op(32'hDEAD_BEEF, 6'd0, 2'b00, 1'b1);   // R2
        op(32'hDEAD_BEEF, 6'd0, 2'b10, 1'b0);   // R2
        op(32'h8000_0001, 6'd1, 2'b00, 1'b0);   // R3 carry bit31
        op(32'h0000_0001, 6'd31, 2'b00, 1'b0);  // R3 carry bit1
        op(32'h0000_0002, 6'd31, 2'b00, 1'b0);  // R3
        op(32'h8000_0001, 6'd1, 2'b01, 1'b0);   // R4 carry bit0
        op(32'h4000_0000, 6'd31, 2'b01, 1'b0);  // R4 carry bit30
        op(32'h8000_0000, 6'd4, 2'b10, 1'b0);   // R5 sign fill
        op(32'h8000_0000, 6'd31, 2'b11, 1'b0);  // R5/R12 alternate code
        op(32'h7FFF_FFFF, 6'd31, 2'b10, 1'b0);  // R5
        op(32'h0000_0001, 6'd32, 2'b00, 1'b0);  // R6 left carry bit0
        op(32'h8000_0000, 6'd32, 2'b01, 1'b0);  // R6 right carry bit31
        op(32'hFFFF_FFFF, 6'd33, 2'b00, 1'b1);  // R7
        op(32'hFFFF_FFFF, 6'd63, 2'b01, 1'b1);  // R7
        op(32'h8000_0000, 6'd32, 2'b10, 1'b0);  // R8
        op(32'h8000_0000, 6'd63, 2'b11, 1'b0);  // R8
        op(32'h7FFF_FFFF, 6'd40, 2'b10, 1'b1);  // R8 positive
        op(32'hFFFF_FFFF, 6'd63, 2'b00, 1'b1);  // R1 top of range

        // R10 hold: strobe low, inputs change, outputs must not move
        held = out_result; heldc = out_carry;
        in_value = 32'h1234_5678; in_count = 6'd0; in_carry = ~heldc;
        @(negedge clk);
        check(out_result == held && out_carry == heldc && !out_done, "R10",
              {out_result, 31'h0, out_done}, {held, 32'h0});

        // Random mix over all counts and kinds (R1, R12)
        for (int i = 0; i < 3000; i++) begin
            op($urandom, 6'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule